// File: doc/BRIEF.md
# Analog Joystick Axis Timer

This block measures the position of up to four analog joystick axes by timing the discharge of an external RC one-shot circuit for each axis. Software selects which axes take part and how fast the counters advance, and then writes one of the start registers. The block fires a one-cycle trigger on each enabled axis and counts prescaled clock ticks for as long as that axis's comparator input stays high. When every enabled axis has finished, it latches the counts, sets a ready flag and can raise an interrupt.

A select field chooses which latched count appears in the two value bytes. In continuous mode the block starts a new measurement on its own after a fixed hold-off, so the latched values keep updating without software action.

The register port is byte wide and has eight locations. The comparator inputs are expected to be synchronous to `clk`. The comparator circuitry and any legacy address decoding sit outside the block.

Top module: `joy_axis_timer`

## Requirements
- R1: After reset, the config register (address 1) reads 0x00, the hardware register (address 4) reads 0x00, all triggers are low and `irq` is low.
- R2: A write to address 2 or 3 starts a measurement. In the cycle after the write edge, `axisTrig` equals the axis-enable mask for exactly one cycle, and the ready flag is low.
- R3: Config bits 3:0 enable axes 1 to 4 (bit n enables axis n+1). An enabled axis latches the number of counter ticks that occurred while its comparator stayed high. At full rate, a comparator held high for W cycles after the trigger yields W-1. A disabled axis latches 0.
- R4: An axis counter stops at 0xFFFF, and that axis counts as finished when the counter reaches it.
- R5: Config bit 7 reads 1 once every enabled axis has finished. It reads 0 from the start of a measurement until then.
- R6: Config bits 5:4 select the axis that is read back: 00 selects axis 1, 01 axis 2, 10 axis 3 and 11 axis 4. Address 2 returns the low byte of the selected count and address 3 returns the high byte.
- R7: Hardware bits 2:1 set the counter rate: 00 is every cycle, 10 is one tick in 2, 01 is one tick in 20 and 11 is one tick in 200. At ratio D, a comparator held high for W cycles yields floor((W-1)/D).
- R8: Hardware bit 0 enables the interrupt. `irq` rises at completion only if this bit is set and at least one axis was enabled. A write to address 4 or a new start clears it.
- R9: Hardware bits 7:3 always read 0. Writes to config bit 7 have no effect.
- R10: With config bit 6 set, a new measurement starts REARM_TICKS cycles after each completion. Once bit 6 is cleared, no further automatic starts occur.
- R11: A write to address 0 starts a measurement in the same way as a write to addresses 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | 3 | Register address |
| regWrEn | input | 1 | Write strobe, one cycle per write |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for `regAddr`, combinational |
| axisComp | input | 4 | Comparator inputs, high while an axis one-shot is timing |
| axisTrig | output | 4 | One-cycle trigger pulses for the enabled axes |
| irq | output | 1 | Completion interrupt, level |

## Verification
A sequencer stuck in or skipping a state shows up at the ports within one cycle: the trigger pulse is missing or stretched, or the ready bit rises too early or too late. A prescaler that is off by one ratio, or a counter that misses the comparator edge, shows up as a wrong latched count as soon as that axis is selected and read after completion. A fault in the hold-off counter moves the next automatic trigger pulse by at least one cycle. The bench's per-cycle reference model catches that at the exact cycle it occurs.

// File: rtl/joy_axis_pkg.sv
package joy_axis_pkg;

  localparam int unsigned AXIS_COUNT = 4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FIRE,
    ST_RUN,
    ST_HOLD
  } seqState_t;

  // strobes from the sequencer to the axis counters
  typedef struct packed {
    logic start;
    logic fire;
    logic run;
    logic tick;
    logic finish;
  } ctlStrobe_t;

  localparam logic [2:0] ADDR_LEGACY   = 3'd0;
  localparam logic [2:0] ADDR_CONFIG   = 3'd1;
  localparam logic [2:0] ADDR_VALUE_LO = 3'd2;
  localparam logic [2:0] ADDR_VALUE_HI = 3'd3;
  localparam logic [2:0] ADDR_HWCFG    = 3'd4;

endpackage

// File: rtl/joy_axis_seq.sv
module joy_axis_seq
  import joy_axis_pkg::*;
#(
  parameter int unsigned REARM_TICKS      = 1000,
  parameter int unsigned DIV_HALF         = 2,
  parameter int unsigned DIV_TWENTIETH    = 20,
  parameter int unsigned DIV_TWOHUNDREDTH = 200
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       contMode,
  input  logic [1:0] rateSel,
  input  logic       allDone,
  output ctlStrobe_t strobe
);

  localparam int unsigned PRE_W  = $clog2(DIV_TWOHUNDREDTH + 1);
  localparam int unsigned HOLD_W = $clog2(REARM_TICKS + 1);

  seqState_t         state;
  logic [PRE_W-1:0]  preCnt;
  logic [PRE_W-1:0]  preLimit;
  logic [HOLD_W-1:0] holdCnt;
  logic              holdExpire;
  logic              startNow;
  logic              finishNow;
  logic              tickNow;

  // rate code to terminal prescaler count
  always_comb begin
    case (rateSel)
      2'b00:   preLimit = '0;
      2'b10:   preLimit = PRE_W'(DIV_HALF - 1);
      2'b01:   preLimit = PRE_W'(DIV_TWENTIETH - 1);
      default: preLimit = PRE_W'(DIV_TWOHUNDREDTH - 1);
    endcase
  end

  assign holdExpire = (state == ST_HOLD) && contMode && (holdCnt == HOLD_W'(REARM_TICKS - 1));
  assign startNow   = startReq || holdExpire;
  assign tickNow    = (state == ST_RUN) && (preCnt >= preLimit);
  assign finishNow  = (state == ST_RUN) && allDone && !startNow;

  always_comb begin
    strobe.start  = startNow;
    strobe.fire   = (state == ST_FIRE);
    strobe.run    = (state == ST_RUN);
    strobe.tick   = tickNow;
    strobe.finish = finishNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      preCnt  <= '0;
      holdCnt <= '0;
    end else if (startNow) begin
      state  <= ST_FIRE;
      preCnt <= '0;
    end else begin
      case (state)
        ST_FIRE: state <= ST_RUN;
        ST_RUN: begin
          preCnt <= tickNow ? '0 : preCnt + 1'b1;
          if (finishNow) begin
            state   <= contMode ? ST_HOLD : ST_IDLE;
            holdCnt <= '0;
          end
        end
        ST_HOLD: begin
          if (!contMode) state <= ST_IDLE;
          else holdCnt <= holdCnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/joy_axis_counters.sv
module joy_axis_counters
  import joy_axis_pkg::*;
#(
  parameter int unsigned NUM_AXES = AXIS_COUNT,
  parameter int unsigned CNT_W    = 16
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  ctlStrobe_t                     strobe,
  input  logic [NUM_AXES-1:0]            enMask,
  input  logic [NUM_AXES-1:0]            axisComp,
  output logic [NUM_AXES-1:0]            axisTrig,
  output logic                           allDone,
  output logic                           anyArmed,
  output logic [NUM_AXES-1:0][CNT_W-1:0] latched
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [NUM_AXES-1:0] doneMask;
  logic [NUM_AXES-1:0] armedMask;

  for (genvar g = 0; g < NUM_AXES; g++) begin : g_axis
    logic [CNT_W-1:0] cntQ;
    logic [CNT_W-1:0] latchQ;
    logic             doneQ;
    logic             armedQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cntQ   <= '0;
        latchQ <= '0;
        doneQ  <= 1'b1;
        armedQ <= 1'b0;
      end else if (strobe.start) begin
        cntQ   <= '0;
        doneQ  <= !enMask[g];
        armedQ <= enMask[g];
      end else begin
        if (strobe.run && !doneQ) begin
          if (!axisComp[g] || (cntQ == CNT_MAX)) doneQ <= 1'b1;
          else if (strobe.tick) cntQ <= cntQ + 1'b1;
        end
        if (strobe.finish) latchQ <= armedQ ? cntQ : '0;
      end
    end

    assign doneMask[g]  = doneQ;
    assign armedMask[g] = armedQ;
    assign latched[g]   = latchQ;
    assign axisTrig[g]  = strobe.fire && armedQ;
  end

  assign allDone  = &doneMask;
  assign anyArmed = |armedMask;

endmodule

// File: rtl/joy_axis_regs.sv
module joy_axis_regs
  import joy_axis_pkg::*;
#(
  parameter int unsigned NUM_AXES = AXIS_COUNT,
  parameter int unsigned CNT_W    = 16
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [2:0]                     regAddr,
  input  logic                           regWrEn,
  input  logic [7:0]                     regWrData,
  input  logic                           startPulse,
  input  logic                           finishPulse,
  input  logic                           anyArmed,
  input  logic [NUM_AXES-1:0][CNT_W-1:0] latched,
  output logic [7:0]                     regRdData,
  output logic [NUM_AXES-1:0]            enMask,
  output logic                           contMode,
  output logic                           irqEn,
  output logic [1:0]                     rateSel,
  output logic                           readyFlag,
  output logic                           irqFlag,
  output logic                           startReq
);

  localparam int unsigned SEL_W = $clog2(NUM_AXES);

  logic [SEL_W-1:0] axisSel;
  logic [15:0]      valueWord;
  logic             cfgWrite;
  logic             hwWrite;
  logic             unusedWrBits;

  assign cfgWrite     = regWrEn && (regAddr == ADDR_CONFIG);
  assign hwWrite      = regWrEn && (regAddr == ADDR_HWCFG);
  assign startReq     = regWrEn && ((regAddr == ADDR_LEGACY) || (regAddr == ADDR_VALUE_LO) ||
                                    (regAddr == ADDR_VALUE_HI));
  assign unusedWrBits = regWrData[7];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enMask   <= '0;
      axisSel  <= '0;
      contMode <= 1'b0;
      irqEn    <= 1'b0;
      rateSel  <= 2'b00;
    end else begin
      if (cfgWrite) begin
        enMask   <= regWrData[NUM_AXES-1:0];
        axisSel  <= regWrData[NUM_AXES +: SEL_W];
        contMode <= regWrData[6];
      end
      if (hwWrite) begin
        irqEn   <= regWrData[0];
        rateSel <= regWrData[2:1];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readyFlag <= 1'b0;
      irqFlag   <= 1'b0;
    end else begin
      if (startPulse) readyFlag <= 1'b0;
      else if (finishPulse) readyFlag <= 1'b1;

      if (startPulse || hwWrite) irqFlag <= 1'b0;
      else if (finishPulse && irqEn && anyArmed) irqFlag <= 1'b1;
    end
  end

  assign valueWord = 16'(latched[axisSel]);

  always_comb begin
    case (regAddr)
      ADDR_CONFIG:   regRdData = {readyFlag, contMode, axisSel, enMask};
      ADDR_VALUE_LO: regRdData = valueWord[7:0];
      ADDR_VALUE_HI: regRdData = valueWord[15:8];
      ADDR_HWCFG:    regRdData = {5'b00000, rateSel, irqEn};
      default:       regRdData = 8'h00;
    endcase
  end

endmodule

// File: rtl/joy_axis_timer.sv
module joy_axis_timer
  import joy_axis_pkg::*;
#(
  parameter int unsigned CNT_W            = 16,
  parameter int unsigned REARM_TICKS      = 1000,
  parameter int unsigned DIV_HALF         = 2,
  parameter int unsigned DIV_TWENTIETH    = 20,
  parameter int unsigned DIV_TWOHUNDREDTH = 200
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] regAddr,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic [3:0] axisComp,
  output logic [3:0] axisTrig,
  output logic       irq
);

  localparam int unsigned NUM_AXES = AXIS_COUNT;

  ctlStrobe_t                     strobe;
  logic [NUM_AXES-1:0]            enMask;
  logic                           contMode;
  logic                           irqEn;
  logic [1:0]                     rateSel;
  logic                           readyFlag;
  logic                           irqFlag;
  logic                           startReq;
  logic                           allDone;
  logic                           anyArmed;
  logic [NUM_AXES-1:0][CNT_W-1:0] latched;

  joy_axis_regs #(.NUM_AXES(NUM_AXES), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .startPulse(strobe.start), .finishPulse(strobe.finish), .anyArmed(anyArmed),
    .latched(latched), .regRdData(regRdData), .enMask(enMask), .contMode(contMode),
    .irqEn(irqEn), .rateSel(rateSel), .readyFlag(readyFlag), .irqFlag(irqFlag),
    .startReq(startReq)
  );

  joy_axis_seq #(
    .REARM_TICKS(REARM_TICKS), .DIV_HALF(DIV_HALF), .DIV_TWENTIETH(DIV_TWENTIETH),
    .DIV_TWOHUNDREDTH(DIV_TWOHUNDREDTH)
  ) u_seq (
    .clk(clk), .rstN(rstN), .startReq(startReq), .contMode(contMode), .rateSel(rateSel),
    .allDone(allDone), .strobe(strobe)
  );

  joy_axis_counters #(.NUM_AXES(NUM_AXES), .CNT_W(CNT_W)) u_counters (
    .clk(clk), .rstN(rstN), .strobe(strobe), .enMask(enMask), .axisComp(axisComp),
    .axisTrig(axisTrig), .allDone(allDone), .anyArmed(anyArmed), .latched(latched)
  );

  assign irq = irqFlag;

endmodule

// File: rtl/joy_axis_checker.sv
module joy_axis_checker (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] regAddr,
  input logic       regWrEn,
  input logic [7:0] regRdData,
  input logic [3:0] axisTrig,
  input logic       irq,
  input logic [3:0] enMask,
  input logic       readyFlag,
  input logic       irqEn,
  input logic       allDone
);

  logic startWrite;
  assign startWrite = regWrEn && ((regAddr == 3'd0) || (regAddr == 3'd2) || (regAddr == 3'd3));

  assert_trig_follows_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    startWrite |=> (axisTrig == $past(enMask)) && !readyFlag);

  assert_trig_single_cycle_R2: assert property (@(posedge clk) disable iff (!rstN)
    ((axisTrig != 4'b0000) && !startWrite) |=> (axisTrig == 4'b0000));

  assert_ready_after_done_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(readyFlag) |-> $past(allDone));

  assert_ready_bit_visible_R5: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 3'd1) |-> (regRdData[7] == readyFlag));

  assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(irqEn));

  assert_irq_implies_ready_R8: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> readyFlag);

  assert_hw_upper_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 3'd4) |-> (regRdData[7:3] == 5'b00000));

endmodule

bind joy_axis_timer joy_axis_checker u_checker (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn), .regRdData(regRdData),
  .axisTrig(axisTrig), .irq(irq), .enMask(enMask), .readyFlag(readyFlag), .irqEn(irqEn),
  .allDone(allDone)
);

// File: tb/joy_axis_timer_bench.sv
module joy_axis_timer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int QTR        = CLK_PERIOD / 4;
  localparam int REARM      = 40;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] regAddr = 3'd0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic [3:0] axisComp = 4'b0000;
  logic [3:0] axisTrig;
  logic       irq;

  joy_axis_timer #(.REARM_TICKS(REARM)) u_joy_axis_timer (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .axisComp(axisComp), .axisTrig(axisTrig), .irq(irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int    nChecks = 0;
  int    nFails = 0;
  string curReq = "R1";
  int    width[4] = '{0, 0, 0, 0};
  int    remain[4] = '{0, 0, 0, 0};

  // behavioural reference state
  int       mState = 0;  // 0 idle, 1 fire, 2 run, 3 hold
  bit [3:0] mEn = 0, mRun = 0, mDone = 4'hF;
  int       mSel = 0, mRate = 0, mPre = 0, mHold = 0;
  bit       mCont = 0, mIrqEn = 0, mReady = 0, mIrq = 0;
  int       mCnt[4] = '{0, 0, 0, 0};
  int       mLatch[4] = '{0, 0, 0, 0};

  function automatic int divOf(int r);
    case (r)
      0: return 1;
      2: return 2;
      1: return 20;
      default: return 200;
    endcase
  endfunction

  function automatic int mRead(int a);
    case (a)
      1: return (int'(mReady) << 7) | (int'(mCont) << 6) | (mSel << 4) | int'(mEn);
      2: return mLatch[mSel] & 255;
      3: return (mLatch[mSel] >> 8) & 255;
      4: return (mRate << 1) | int'(mIrqEn);
      default: return 0;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act,
                       input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin : model
    bit st, fin, tick, wHw, wCfg, holdStart, anyRun;
    if (!rstN) begin
      mState = 0; mEn = 0; mRun = 0; mDone = 4'hF; mSel = 0; mRate = 0; mPre = 0;
      mHold = 0; mCont = 0; mIrqEn = 0; mReady = 0; mIrq = 0;
      for (int i = 0; i < 4; i++) begin mCnt[i] = 0; mLatch[i] = 0; end
    end else begin
      wHw       = regWrEn && (regAddr == 3'd4);
      wCfg      = regWrEn && (regAddr == 3'd1);
      holdStart = (mState == 3) && mCont && (mHold == REARM - 1);
      st        = (regWrEn && (regAddr == 3'd0 || regAddr == 3'd2 || regAddr == 3'd3)) || holdStart;
      fin       = (mState == 2) && (mDone == 4'hF) && !st;
      tick      = (mState == 2) && (mPre >= divOf(mRate) - 1);
      anyRun    = (mRun != 0);
      // axis counters
      for (int i = 0; i < 4; i++) begin
        if (st) begin
          mCnt[i] = 0; mDone[i] = !mEn[i]; mRun[i] = mEn[i];
        end else begin
          if (mState == 2 && !mDone[i]) begin
            if (!axisComp[i] || mCnt[i] == 65535) mDone[i] = 1;
            else if (tick) mCnt[i]++;
          end
          if (fin) mLatch[i] = mRun[i] ? mCnt[i] : 0;
        end
      end
      // flags
      if (st) mReady = 0; else if (fin) mReady = 1;
      if (st || wHw) mIrq = 0; else if (fin && mIrqEn && anyRun) mIrq = 1;
      // sequencer
      if (st) begin
        mState = 1; mPre = 0;
      end else begin
        case (mState)
          1: mState = 2;
          2: begin
            mPre = tick ? 0 : mPre + 1;
            if (fin) begin mState = mCont ? 3 : 0; mHold = 0; end
          end
          3: begin
            if (!mCont) mState = 0; else mHold++;
          end
          default: mState = 0;
        endcase
      end
      // register writes last, so all decisions above used old values
      if (wCfg) begin
        mEn = regWrData[3:0]; mSel = int'(regWrData[5:4]); mCont = regWrData[6];
      end
      if (wHw) begin
        mIrqEn = regWrData[0]; mRate = int'(regWrData[2:1]);
      end
    end
  end

  // per-cycle comparison and comparator stimulus, a quarter period after the edge
  always begin
    @(posedge clk);
    #(QTR);
    if (rstN) begin
      check(axisTrig == ((mState == 1) ? mRun : 4'b0000), curReq, "trig", int'(axisTrig),
            int'((mState == 1) ? mRun : 4'b0000));
      check(irq == mIrq, curReq, "irq", int'(irq), int'(mIrq));
      check(int'(regRdData) == mRead(int'(regAddr)), curReq, "rdData", int'(regRdData),
            mRead(int'(regAddr)));
    end
    for (int i = 0; i < 4; i++) begin
      if (mState == 1) remain[i] = width[i];
      else if (remain[i] > 0) remain[i]--;
      axisComp[i] = (remain[i] > 0);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrEn = 1'b1; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic chkRd(input logic [2:0] a, input int exp, input string req);
    @(negedge clk);
    regAddr = a;
    #1;
    check(int'(regRdData) == exp, req, "read", int'(regRdData), exp);
  endtask

  task automatic waitIdle();
    int guard = 0;
    while ((mState == 1 || mState == 2) && guard < 150000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finishRun();
  end

  initial begin
    int pulses;
    int rates[4] = '{8'h05, 8'h03, 8'h07, 8'h01};
    int ws[4] = '{41, 401, 2001, 25};
    int exps[4] = '{20, 20, 10, 24};
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    curReq = "R1";
    chkRd(3'd1, 0, "R1");
    chkRd(3'd4, 0, "R1");
    check(axisTrig == 4'b0000, "R1", "trig", int'(axisTrig), 0);
    check(irq == 1'b0, "R1", "irq", int'(irq), 0);

    // R2/R3/R5/R6/R8 basic measurement, axes 1 and 3
    curReq = "R2";
    width = '{10, 20, 30, 40};
    wr(3'd1, 8'h05);
    wr(3'd4, 8'h01);
    wr(3'd2, 8'h00);
    check(axisTrig == 4'b0101, "R2", "trig after start", int'(axisTrig), 5);
    chkRd(3'd1, 8'h05, "R5");
    curReq = "R3";
    waitIdle();
    chkRd(3'd2, 9, "R3");
    chkRd(3'd3, 0, "R6");
    wr(3'd1, 8'h25);
    chkRd(3'd2, 29, "R6");
    wr(3'd1, 8'h15);
    chkRd(3'd2, 0, "R3");
    check(irq == 1'b1, "R8", "irq at completion", int'(irq), 1);
    chkRd(3'd1, 8'h95, "R5");
    curReq = "R8";
    wr(3'd4, 8'h01);
    check(irq == 1'b0, "R8", "irq after hw write", int'(irq), 0);

    // R7 prescaler ratios, R11 legacy start
    curReq = "R7";
    wr(3'd1, 8'h01);
    for (int k = 0; k < 4; k++) begin
      width = '{ws[k], 0, 0, 0};
      wr(3'd4, 8'(rates[k]));
      if (k == 0) begin
        wr(3'd0, 8'h5A);
        check(axisTrig == 4'b0001, "R11", "legacy start trig", int'(axisTrig), 1);
      end else begin
        wr(3'd3, 8'h00);
      end
      waitIdle();
      chkRd(3'd2, exps[k] & 255, "R7");
      chkRd(3'd3, exps[k] >> 8, "R7");
    end

    // R9 reserved bits
    curReq = "R9";
    wr(3'd4, 8'hFF);
    chkRd(3'd4, 8'h07, "R9");
    wr(3'd4, 8'h01);
    width = '{300, 0, 0, 0};
    wr(3'd2, 8'h00);
    wr(3'd1, 8'h81);
    chkRd(3'd1, 8'h01, "R9");
    waitIdle();
    chkRd(3'd1, 8'h81, "R5");

    // R4 saturation
    curReq = "R4";
    wr(3'd4, 8'h00);
    width = '{100000, 0, 0, 0};
    wr(3'd2, 8'h00);
    waitIdle();
    chkRd(3'd2, 8'hFF, "R4");
    chkRd(3'd3, 8'hFF, "R4");

    // R8 no axes enabled: completion without interrupt
    curReq = "R8";
    wr(3'd4, 8'h01);
    wr(3'd1, 8'h00);
    wr(3'd2, 8'h00);
    waitIdle();
    repeat (2) @(negedge clk);
    check(irq == 1'b0, "R8", "irq with no axes", int'(irq), 0);
    chkRd(3'd1, 8'h80, "R8");

    // R10 continuous mode
    curReq = "R10";
    width = '{5, 0, 0, 0};
    wr(3'd1, 8'h41);
    wr(3'd2, 8'h00);
    pulses = 0;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      if (axisTrig != 4'b0000) pulses++;
    end
    check(pulses >= 3, "R10", "auto restarts", pulses, 3);
    wr(3'd1, 8'h01);
    waitIdle();
    pulses = 0;
    for (int c = 0; c < 150; c++) begin
      @(negedge clk);
      if (axisTrig != 4'b0000) pulses++;
    end
    check(pulses == 0, "R10", "no restart after clear", pulses, 0);
    chkRd(3'd2, 4, "R10");

    finishRun();
  end

endmodule